// File: doc/BRIEF.md
# Vector Load Address Sequencer

This block walks one vector load instruction and produces the memory address of every element, one address per handshake. A start pulse supplies a scalar base address, an element size in bytes, a stride mode bit with an optional scalar stride, an indexed flag, the vector length, a segment length and a predicate mask. The sequencer then visits element positions from the lowest to the highest. For every active element it emits one address for each member of the segment group. Each address carries the destination register number and the element position it belongs to.

The outer loop steps the element position i from 0 up to vl-1. The inner loop steps the segment member j from 0 up to seglen inclusive. In indexed mode the byte offset of an element is fetched through a request/response port, one request per active element, and that offset is held while all of the element's members are emitted. In the other modes the offset is i·(seglen+1)·stride. A member address is always base + offset + j·stride. Masked elements are skipped completely: they produce no fetch and no address. Issuing the addresses to memory, returning data and decoding instructions are all handled elsewhere.

Top module: `vld_addr_seq`

## Requirements
- R1: While reset is active, and directly after it, `busy_o`, `done_o`, `addr_valid_o` and `idx_req_valid_o` are all low.
- R2: When `stride_mode_i` is 0 (unit stride), the stride equals `esz_i` bytes. Element i, member j gets the address base + i·(seglen+1)·esz + j·esz.
- R3: When `stride_mode_i` is 1, the stride is `stride_i`. Element i, member j gets the address base + i·(seglen+1)·stride + j·stride.
- R4: When `indexed_i` is 1, the block raises `idx_req_valid_o` once per active element, with `idx_req_elem_o` = i. It holds the request until `idx_rsp_valid_i` arrives. Member j then gets the address base + data + j·stride, where the stride is the one selected by R2 or R3 and is never the element size unless unit stride is selected.
- R5: Addresses leave in ascending i, and in ascending j within an element. Each address carries `addr_vreg_o` = (vd + j) mod 32 and `addr_elem_o` = i.
- R6: An element whose `mask_i` bit is 0, or whose position is vl or above, produces no address and no index request.
- R7: `busy_o` is high from the cycle after an accepted start until `done_o`. `done_o` is a one-cycle pulse in the cycle after the last address handshake, and `busy_o` is low in that cycle.
- R8: When vl is 0 or no element is active, `done_o` pulses in the cycle after start and no address or request appears.
- R9: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_valid_o`, `addr_o`, `addr_vreg_o` and `addr_elem_o` keep their values into the next cycle.
- R10: All address sums and products wrap modulo 2^32.
- R11: A start pulse that arrives while `busy_o` is high is ignored, and the running sequence is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sequence; samples all configuration inputs |
| base_i | input | AW | Scalar base address |
| esz_i | input | 4 | Element size in bytes (unit-stride step) |
| stride_mode_i | input | 1 | 0 = unit stride, 1 = step by `stride_i` |
| stride_i | input | AW | Scalar stride in bytes |
| indexed_i | input | 1 | Offsets come from the index port |
| vl_i | input | VLW+1 | Vector length, 0 to VLMAX |
| seglen_i | input | SEGW | Segment members minus one |
| vd_i | input | REGW | First destination register |
| mask_i | input | VLMAX | Predicate, bit i enables element i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| idx_req_valid_o | output | 1 | Index offset requested |
| idx_req_elem_o | output | VLW | Element whose offset is requested |
| idx_rsp_valid_i | input | 1 | Index offset returned |
| idx_rsp_data_i | input | AW | Returned byte offset |
| addr_valid_o | output | 1 | Address available |
| addr_ready_i | input | 1 | Consumer takes the address |
| addr_o | output | AW | Element address |
| addr_vreg_o | output | REGW | Destination register of this address |
| addr_elem_o | output | VLW | Element position of this address |

## Verification
In non-indexed modes the first address is valid in the cycle after start. In indexed mode, and after each index response, it is valid in the cycle after the response. The next address follows in the cycle after each handshake. `done_o` is due exactly one cycle after the last handshake, or one cycle after start for an empty job. The bench drives every input and samples every output on the falling edge, so a handshake it grants at one falling edge completes at the next rising edge. Its reference queues pop at the falling edge where it grants the handshake, and the cycle number at which done is due is recorded at that same point. Every falling edge compares the stalled address with the one held over from the previous cycle. The index responder answers after a variable delay and checks each request element when it first appears.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EMIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vls_rst_sync.sv
module vls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/vls_scan.sv
// Finds the lowest active element position at or above a start point.
module vls_scan #(
  parameter int VLMAX = 64,
  localparam int VLW  = $clog2(VLMAX)
) (
  input  logic [VLMAX-1:0] mask_i,
  input  logic [VLW:0]     vl_i,
  input  logic [VLW:0]     from_i,
  output logic             hit_o,
  output logic [VLW-1:0]   idx_o
);
  logic [VLMAX-1:0] act;

  for (genvar k = 0; k < VLMAX; k++) begin : g_act
    localparam logic [VLW:0] POS = (VLW+1)'(k);
    assign act[k] = mask_i[k] && (POS < vl_i) && (POS >= from_i);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = VLMAX-1; k >= 0; k--) begin
      if (act[k]) begin
        hit_o = 1'b1;
        idx_o = VLW'(k);
      end
    end
  end
endmodule

// File: rtl/vls_offset.sv
// Offset of an element in the non-indexed modes: i*(seglen+1)*stride, modulo 2^AW.
module vls_offset #(
  parameter int AW   = 32,
  parameter int VLW  = 6,
  parameter int SEGW = 3
) (
  input  logic [VLW-1:0]  elem_i,
  input  logic [SEGW-1:0] seglen_i,
  input  logic [AW-1:0]   stride_i,
  output logic [AW-1:0]   off_o
);
  logic [AW-1:0] elem_w;
  logic [AW-1:0] group_w;

  assign elem_w  = AW'(elem_i);
  assign group_w = AW'(seglen_i) + AW'(1);
  assign off_o   = elem_w * group_w * stride_i;
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
#(
  parameter int AW   = 32,
  parameter int VLW  = 6,
  parameter int SEGW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            indexed_i,
  input  logic [SEGW-1:0] seglen_i,
  input  logic [AW-1:0]   stride_i,
  input  logic            hit_i,
  input  logic [VLW-1:0]  hit_idx_i,
  input  logic [AW-1:0]   elem_off_i,
  input  logic            rsp_valid_i,
  input  logic [AW-1:0]   rsp_data_i,
  input  logic            ready_i,
  output logic [VLW:0]    scan_from_o,
  output logic            idle_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            req_valid_o,
  output logic            addr_valid_o,
  output logic [VLW-1:0]  elem_o,
  output logic [SEGW-1:0] member_o,
  output logic [AW-1:0]   off_o,
  output logic [AW-1:0]   acc_o
);
  seq_state_e      st_q, st_d;
  logic [VLW-1:0]  elem_q, elem_d;
  logic [SEGW-1:0] mem_q, mem_d;
  logic [AW-1:0]   off_q, off_d;
  logic [AW-1:0]   acc_q, acc_d;
  logic            done_q, done_d;
  logic            adv_en;
  logic            load_elem;

  // next-state process
  always_comb begin
    st_d      = st_q;
    elem_d    = elem_q;
    mem_d     = mem_q;
    off_d     = off_q;
    acc_d     = acc_q;
    done_d    = 1'b0;
    adv_en    = 1'b0;
    load_elem = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          adv_en = 1'b1;
          if (hit_i) load_elem = 1'b1;
          else       done_d    = 1'b1;
        end
      end
      ST_FETCH: begin
        if (rsp_valid_i) begin
          adv_en = 1'b1;
          off_d  = rsp_data_i;
          mem_d  = '0;
          acc_d  = '0;
          st_d   = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (ready_i) begin
          adv_en = 1'b1;
          if (mem_q == seglen_i) begin
            if (hit_i) begin
              load_elem = 1'b1;
            end else begin
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end
          end else begin
            mem_d = mem_q + 1'b1;
            acc_d = acc_q + stride_i;
          end
        end
      end
      default: begin
        adv_en = 1'b1;
        st_d   = ST_IDLE;
      end
    endcase
    if (load_elem) begin
      elem_d = hit_idx_i;
      mem_d  = '0;
      acc_d  = '0;
      if (indexed_i) begin
        st_d = ST_FETCH;
      end else begin
        off_d = elem_off_i;
        st_d  = ST_EMIT;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      elem_q <= '0;
      mem_q  <= '0;
      off_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (adv_en) begin
        st_q   <= st_d;
        elem_q <= elem_d;
        mem_q  <= mem_d;
        off_q  <= off_d;
        acc_q  <= acc_d;
      end
    end
  end

  assign idle_o       = (st_q == ST_IDLE);
  assign busy_o       = !idle_o;
  assign done_o       = done_q;
  assign req_valid_o  = (st_q == ST_FETCH);
  assign addr_valid_o = (st_q == ST_EMIT);
  assign elem_o       = elem_q;
  assign member_o     = mem_q;
  assign off_o        = off_q;
  assign acc_o        = acc_q;
  assign scan_from_o  = idle_o ? '0 : ({1'b0, elem_q} + 1'b1);
endmodule

// File: rtl/vld_addr_seq.sv
module vld_addr_seq #(
  parameter int AW    = 32,
  parameter int VLMAX = 64,
  parameter int SEGW  = 3,
  parameter int REGW  = 5,
  localparam int VLW  = $clog2(VLMAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic [3:0]       esz_i,
  input  logic             stride_mode_i,
  input  logic [AW-1:0]    stride_i,
  input  logic             indexed_i,
  input  logic [VLW:0]     vl_i,
  input  logic [SEGW-1:0]  seglen_i,
  input  logic [REGW-1:0]  vd_i,
  input  logic [VLMAX-1:0] mask_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             idx_req_valid_o,
  output logic [VLW-1:0]   idx_req_elem_o,
  input  logic             idx_rsp_valid_i,
  input  logic [AW-1:0]    idx_rsp_data_i,
  output logic             addr_valid_o,
  input  logic             addr_ready_i,
  output logic [AW-1:0]    addr_o,
  output logic [REGW-1:0]  addr_vreg_o,
  output logic [VLW-1:0]   addr_elem_o
);
  logic rst_n_int;

  // job configuration held for the length of a sequence
  logic [AW-1:0]    base_q, stride_q;
  logic             indexed_q;
  logic [VLW:0]     vl_q;
  logic [SEGW-1:0]  seglen_q;
  logic [REGW-1:0]  vd_q;
  logic [VLMAX-1:0] mask_q;

  logic [AW-1:0]    stride_in;
  logic             idle;
  logic             cfg_en;

  // view used by the scanner and offset unit: live inputs while idle
  logic [AW-1:0]    v_stride;
  logic             v_indexed;
  logic [VLW:0]     v_vl;
  logic [SEGW-1:0]  v_seglen;
  logic [VLMAX-1:0] v_mask;

  logic [VLW:0]     scan_from;
  logic             hit;
  logic [VLW-1:0]   hit_idx;
  logic [AW-1:0]    elem_off;
  logic [VLW-1:0]   elem;
  logic [SEGW-1:0]  member;
  logic [AW-1:0]    off;
  logic [AW-1:0]    acc;

  vls_rst_sync u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  assign stride_in = stride_mode_i ? stride_i : AW'(esz_i);
  assign cfg_en    = start_i && idle;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      base_q    <= '0;
      stride_q  <= '0;
      indexed_q <= 1'b0;
      vl_q      <= '0;
      seglen_q  <= '0;
      vd_q      <= '0;
      mask_q    <= '0;
    end else if (cfg_en) begin
      base_q    <= base_i;
      stride_q  <= stride_in;
      indexed_q <= indexed_i;
      vl_q      <= vl_i;
      seglen_q  <= seglen_i;
      vd_q      <= vd_i;
      mask_q    <= mask_i;
    end
  end

  always_comb begin
    if (idle) begin
      v_stride  = stride_in;
      v_indexed = indexed_i;
      v_vl      = vl_i;
      v_seglen  = seglen_i;
      v_mask    = mask_i;
    end else begin
      v_stride  = stride_q;
      v_indexed = indexed_q;
      v_vl      = vl_q;
      v_seglen  = seglen_q;
      v_mask    = mask_q;
    end
  end

  vls_scan #(.VLMAX(VLMAX)) u_scan (
    .mask_i (v_mask),
    .vl_i   (v_vl),
    .from_i (scan_from),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  vls_offset #(.AW(AW), .VLW(VLW), .SEGW(SEGW)) u_off (
    .elem_i   (hit_idx),
    .seglen_i (v_seglen),
    .stride_i (v_stride),
    .off_o    (elem_off)
  );

  vls_ctrl #(.AW(AW), .VLW(VLW), .SEGW(SEGW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start_i      (start_i),
    .indexed_i    (v_indexed),
    .seglen_i     (v_seglen),
    .stride_i     (v_stride),
    .hit_i        (hit),
    .hit_idx_i    (hit_idx),
    .elem_off_i   (elem_off),
    .rsp_valid_i  (idx_rsp_valid_i),
    .rsp_data_i   (idx_rsp_data_i),
    .ready_i      (addr_ready_i),
    .scan_from_o  (scan_from),
    .idle_o       (idle),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .req_valid_o  (idx_req_valid_o),
    .addr_valid_o (addr_valid_o),
    .elem_o       (elem),
    .member_o     (member),
    .off_o        (off),
    .acc_o        (acc)
  );

  assign idx_req_elem_o = elem;
  assign addr_elem_o    = elem;
  assign addr_o         = base_q + off + acc;
  assign addr_vreg_o    = vd_q + REGW'(member);
endmodule

// File: rtl/vld_addr_seq_chk.sv
module vld_addr_seq_chk #(
  parameter int AW    = 32,
  parameter int VLMAX = 64,
  parameter int REGW  = 5,
  localparam int VLW  = $clog2(VLMAX)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             indexed_i,
  input logic [VLW:0]     vl_i,
  input logic [VLMAX-1:0] mask_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             idx_req_valid_o,
  input logic [VLW-1:0]   idx_req_elem_o,
  input logic             idx_rsp_valid_i,
  input logic             addr_valid_o,
  input logic             addr_ready_i,
  input logic [AW-1:0]    addr_o,
  input logic [REGW-1:0]  addr_vreg_o,
  input logic [VLW-1:0]   addr_elem_o
);
  logic [VLMAX-1:0] chk_mask;
  logic [VLW:0]     chk_vl;
  logic             chk_indexed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_mask    <= '0;
      chk_vl      <= '0;
      chk_indexed <= 1'b0;
    end else if (start_i && !busy_o) begin
      chk_mask    <= mask_i;
      chk_vl      <= vl_i;
      chk_indexed <= indexed_i;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o)
      && $stable(addr_vreg_o) && $stable(addr_elem_o));

  a_r6_active_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> chk_mask[addr_elem_o] && (addr_elem_o < chk_vl));

  a_r6_active_req: assert property (@(posedge clk) disable iff (!rst_n)
    idx_req_valid_o |-> chk_mask[idx_req_elem_o] && (idx_req_elem_o < chk_vl));

  a_r4_req_only_indexed: assert property (@(posedge clk) disable iff (!rst_n)
    idx_req_valid_o |-> chk_indexed && !addr_valid_o);

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idx_req_valid_o && !idx_rsp_valid_i |=> idx_req_valid_o && $stable(idx_req_elem_o));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !addr_valid_o && !idx_req_valid_o);

  a_r7_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> busy_o);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o || $past(start_i));
endmodule

bind vld_addr_seq vld_addr_seq_chk #(.AW(AW), .VLMAX(VLMAX), .REGW(REGW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .indexed_i       (indexed_i),
  .vl_i            (vl_i),
  .mask_i          (mask_i),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .idx_req_valid_o (idx_req_valid_o),
  .idx_req_elem_o  (idx_req_elem_o),
  .idx_rsp_valid_i (idx_rsp_valid_i),
  .addr_valid_o    (addr_valid_o),
  .addr_ready_i    (addr_ready_i),
  .addr_o          (addr_o),
  .addr_vreg_o     (addr_vreg_o),
  .addr_elem_o     (addr_elem_o)
);

// File: tb/tb_vld_addr_seq.sv
module tb_vld_addr_seq;
  localparam int AW = 32, VLMAX = 64, SEGW = 3, REGW = 5, VLW = 6;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [AW-1:0]    base_i;
  logic [3:0]       esz_i;
  logic             stride_mode_i;
  logic [AW-1:0]    stride_i;
  logic             indexed_i;
  logic [VLW:0]     vl_i;
  logic [SEGW-1:0]  seglen_i;
  logic [REGW-1:0]  vd_i;
  logic [VLMAX-1:0] mask_i;
  logic             busy_o, done_o;
  logic             idx_req_valid_o;
  logic [VLW-1:0]   idx_req_elem_o;
  logic             idx_rsp_valid_i;
  logic [AW-1:0]    idx_rsp_data_i;
  logic             addr_valid_o;
  logic             addr_ready_i;
  logic [AW-1:0]    addr_o;
  logic [REGW-1:0]  addr_vreg_o;
  logic [VLW-1:0]   addr_elem_o;

  vld_addr_seq dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] exp_addr[$];
  logic [4:0]  exp_vreg[$];
  int          exp_elem[$];
  int          exp_fetch[$];
  logic [31:0] idx_tab[64];
  string       job_tag = "R2";
  bit          exp_empty = 0;
  bit          job_done = 0;
  int          done_due = -10;
  int          n_xfer = 0;
  bit          mon_en = 0;
  bit          ready_force = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          prev_stall = 0;
  logic [31:0] prev_addr;
  logic [4:0]  prev_vreg;
  logic [5:0]  prev_elem;
  bit          rsp_pending = 0;
  int          rsp_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor, ready driver and index responder, all on the falling edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_stall) begin
        chk(addr_valid_o == 1'b1, "R9", "valid dropped during stall", 32'(addr_valid_o), 1);
        chk(addr_o == prev_addr && addr_vreg_o == prev_vreg && addr_elem_o == prev_elem,
            "R9", "address changed during stall", addr_o, prev_addr);
      end
      if (done_o) begin
        chk(cyc == done_due, exp_empty ? "R8" : "R7", "done cycle", 32'(cyc), 32'(done_due));
        chk(busy_o == 1'b0, "R7", "busy during done", 32'(busy_o), 0);
        job_done = 1;
      end else if (cyc == done_due) begin
        chk(1'b0, exp_empty ? "R8" : "R7", "done missing", 0, 1);
        job_done = 1;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      addr_ready_i = ready_force | lfsr[0] | lfsr[3];
      if (addr_valid_o && addr_ready_i) begin
        n_xfer++;
        if (exp_addr.size() == 0) begin
          chk(1'b0, "R6", "unexpected address", addr_o, 0);
        end else begin
          chk(addr_o == exp_addr[0], job_tag, "address", addr_o, exp_addr[0]);
          chk(addr_vreg_o == exp_vreg[0] && 32'(addr_elem_o) == exp_elem[0], "R5",
              "vreg/elem", {addr_vreg_o, 8'h0, 2'b0, addr_elem_o},
              {exp_vreg[0], 8'h0, 32'(exp_elem[0])}[31:0]);
          void'(exp_addr.pop_front());
          void'(exp_vreg.pop_front());
          void'(exp_elem.pop_front());
          if (exp_addr.size() == 0) done_due = cyc + 1;
        end
      end
      prev_stall = addr_valid_o && !addr_ready_i;
      prev_addr  = addr_o;
      prev_vreg  = addr_vreg_o;
      prev_elem  = addr_elem_o;
      if (idx_rsp_valid_i) begin
        idx_rsp_valid_i = 1'b0;
      end else if (rsp_pending) begin
        if (rsp_cnt == 0) begin
          idx_rsp_valid_i = 1'b1;
          idx_rsp_data_i  = idx_tab[idx_req_elem_o];
          rsp_pending     = 0;
        end else begin
          rsp_cnt--;
        end
      end else if (idx_req_valid_o) begin
        if (exp_fetch.size() == 0) begin
          chk(1'b0, "R6", "unexpected index request", 32'(idx_req_elem_o), 0);
        end else begin
          chk(32'(idx_req_elem_o) == exp_fetch[0], "R4", "index request element",
              32'(idx_req_elem_o), 32'(exp_fetch[0]));
          void'(exp_fetch.pop_front());
        end
        rsp_pending = 1;
        rsp_cnt     = int'(lfsr[5:4]);
      end
    end
  end

  task automatic run_job(input string tag, input string cnt_tag, input bit strided,
                         input logic [31:0] stride, input logic [3:0] esz, input bit idx,
                         input int vl, input int seg, input logic [4:0] vd,
                         input logic [63:0] mask, input logic [31:0] base, input bit mid_start);
    logic [31:0] st, off;
    int n_exp = 0;
    int t = 0;
    st = strided ? stride : {28'b0, esz};
    for (int i = 0; i < vl; i++) begin
      if (mask[i]) begin
        off = idx ? idx_tab[i] : 32'(i) * (32'(seg) + 32'd1) * st;
        if (idx) exp_fetch.push_back(i);
        for (int j = 0; j <= seg; j++) begin
          exp_addr.push_back(base + off + 32'(j) * st);
          exp_vreg.push_back(vd + 5'(j));
          exp_elem.push_back(i);
          n_exp++;
        end
      end
    end
    job_tag   = tag;
    exp_empty = (n_exp == 0);
    job_done  = 0;
    n_xfer    = 0;
    @(negedge clk);
    if (exp_empty) done_due = cyc + 1;
    base_i = base; esz_i = esz; stride_mode_i = strided; stride_i = stride;
    indexed_i = idx; vl_i = 7'(vl); seglen_i = 3'(seg); vd_i = vd; mask_i = mask;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!exp_empty) chk(busy_o == 1'b1, "R7", "busy after start", 32'(busy_o), 1);
    else chk(addr_valid_o == 1'b0 && idx_req_valid_o == 1'b0, "R8", "activity on empty job",
             32'({addr_valid_o, idx_req_valid_o}), 0);
    if (mid_start) begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b1, "R11", "busy before extra start", 32'(busy_o), 1);
      base_i = 32'hDEAD_0000; vl_i = '0; mask_i = '0; indexed_i = 1'b1; seglen_i = 3'd7;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!job_done && t < 4000) begin
      @(negedge clk);
      t++;
    end
    if (!job_done) chk(1'b0, tag, "job timed out", 0, 1);
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R7", "idle after done", 32'({busy_o, done_o}), 0);
    chk(n_xfer == n_exp && exp_addr.size() == 0 && exp_fetch.size() == 0, cnt_tag,
        "address count", 32'(n_xfer), 32'(n_exp));
    exp_addr.delete(); exp_vreg.delete(); exp_elem.delete(); exp_fetch.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; esz_i = 4'd4; stride_mode_i = 1'b0;
    stride_i = '0; indexed_i = 1'b0; vl_i = '0; seglen_i = '0; vd_i = '0; mask_i = '0;
    idx_rsp_valid_i = 1'b0; idx_rsp_data_i = '0; addr_ready_i = 1'b0;
    for (int i = 0; i < 64; i++) idx_tab[i] = 32'h0000_0400 + 32'(i) * 32'h1C0 ^ (32'(i) << 12);
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, addr_valid_o, idx_req_valid_o} == 4'b0, "R1", "outputs in reset",
        32'({busy_o, done_o, addr_valid_o, idx_req_valid_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy_o, done_o, addr_valid_o, idx_req_valid_o} == 4'b0, "R1", "outputs after reset",
        32'({busy_o, done_o, addr_valid_o, idx_req_valid_o}), 0);
    mon_en = 1;

    run_job("R2", "R6", 0, 32'h0, 4'd4, 0, 8, 0, 5'd1, 64'hFF, 32'h0000_1000, 0);
    run_job("R2", "R6", 0, 32'h0, 4'd2, 0, 5, 2, 5'd30, 64'b10110, 32'h0000_2000, 0);
    run_job("R3", "R11", 1, 32'h100, 4'd4, 0, 6, 1, 5'd4, 64'b101101, 32'h0000_8000, 1);
    run_job("R4", "R6", 0, 32'h0, 4'd8, 1, 7, 1, 5'd8, 64'b1101011, 32'h0010_0000, 0);
    run_job("R4", "R6", 1, 32'hFFFF_FFFC, 4'd1, 1, 9, 2, 5'd29, 64'h1F3, 32'h0020_0000, 0);
    run_job("R8", "R8", 0, 32'h0, 4'd4, 0, 0, 0, 5'd0, 64'hFF, 32'h0000_3000, 0);
    run_job("R8", "R8", 1, 32'h40, 4'd4, 1, 12, 3, 5'd2, 64'h0, 32'h0000_3000, 0);
    run_job("R10", "R6", 1, 32'h10, 4'd4, 0, 4, 1, 5'd0, 64'hF, 32'hFFFF_FFE8, 0);
    ready_force = 1;
    run_job("R3", "R6", 1, 32'h24, 4'd4, 0, 64, 0, 5'd3, 64'hF0F0_AAAA_5555_FFFF, 32'h4000_0000, 0);
    ready_force = 0;
    run_job("R2", "R6", 0, 32'h0, 4'd1, 0, 3, 7, 5'd28, 64'b100, 32'h0000_0500, 0);

    repeat (3) @(negedge clk);
    finish_sim();
  end
endmodule